// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the bus-side controller of a small non-volatile memory that sits on a two-wire I2C bus as a slave. It watches SCL and SDA, which it oversamples with the system clock. It recognises its own select byte using a fixed device code and three strap inputs. It keeps an 8-bit word pointer into a 256-byte array and drives SDA only through an open-drain enable, which pulls the line low when set.

Writes collect up to eight data bytes in a page latch. The latch goes into the array only when the master closes the transfer with STOP, and a fixed-length internal write cycle then begins. While that cycle runs, the slave stays silent on the bus. Reads send bytes from the pointer onwards and advance after every byte that the master acknowledges. Random access is done by first sending only a word address in write mode, then a repeated START in read mode.

The write-cycle length comes from an internal prescaler followed by a tick counter. With the defaults these are 128 and 16, so the cycle lasts 2048 clocks. No external timing input is used.

Top module: `sermem_i2c_slave`

## Requirements
- R1: A select byte is accepted only when bits 7..4 are 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 selects read (1) or write (0), and the byte is sent MSB first. Any other select byte is not acknowledged, and the slave ignores the bus until the next START or STOP.
- R2: For each accepted byte, sda_oe_o is high throughout the SCL-high phase of the ninth clock. In every other SCL-high phase, sda_oe_o is low unless the slave is sending a 0 read bit. The enable changes only after a falling SCL edge, or on START or STOP.
- R3: After reset the bus logic is idle, sda_oe_o is low, and every array location reads 0xFF.
- R4: A write of one data byte followed by STOP changes only the addressed location.
- R5: In a write, data bytes advance only pointer bits 2..0. A ninth or later byte wraps inside the same 8-byte page and replaces the byte latched earlier for that slot.
- R6: A write select, then a word address, then a repeated START with a read select returns the byte at that address.
- R7: In a read, the pointer advances by one after each byte the master acknowledges, and wraps from 0xFF to 0x00. A NACK from the master releases SDA and ends the read.
- R8: A STOP after at least one latched data byte starts a write cycle of WR_DIV*WR_TICKS clocks. During that cycle select bytes are not acknowledged, and after it ends they are acknowledged again.
- R9: A START that arrives before STOP discards the latched bytes. The array is unchanged and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| strap_i | input | 3 | Board-level device address straps |
| sda_oe_o | output | 1 | Pull SDA low when high (open-drain enable) |

## Verification
Most internal faults show up on sda_oe_o within one bit time. A wrong state or bit count misplaces the acknowledge or a read bit in the very next SCL-high phase, and the bench compares the enable against its expected value on every clock of every high phase. A wrong pointer, page index or latch mask is silent until the affected location is read back. For that reason every write is followed by reads that cover the page neighbours and the 0xFF-to-0x00 wrap. A timer fault appears as an acknowledge given or refused on the first select after a STOP.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

   // bus-side protocol states
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_SEL_ACK,
      ST_ADR,
      ST_ADR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } bus_st_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
   localparam int         BYTE_W   = 8;

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sermem_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q;
   logic              scl_now, sda_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_now    = scl_sh[STAGES-1];
   assign sda_now    = sda_sh[STAGES-1];
   assign sda_o      = sda_now;
   assign scl_rise_o = scl_now & ~scl_q;
   assign scl_fall_o = ~scl_now & scl_q;
   assign start_o    = scl_now & scl_q & sda_q & ~sda_now;
   assign stop_o     = scl_now & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/sermem_wtimer.sv
module sermem_wtimer #(
   parameter int DIV   = 128,
   parameter int TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   generate
      if (DIV < 2 || TICKS < 2) begin : g_bad_timer
         $error("sermem_wtimer: DIV and TICKS must both be at least 2");
      end
   endgenerate

   localparam int DW = $clog2(DIV);
   localparam int TW = $clog2(TICKS);

   logic [DW-1:0] pre;
   logic [TW-1:0] tick;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre    <= '0;
         tick   <= '0;
         busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
         pre    <= '0;
         tick   <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (pre == DW'(DIV - 1)) begin
            pre <= '0;
            if (tick == TW'(TICKS - 1)) busy_q <= 1'b0;
            else                         tick   <= tick + TW'(1);
         end else begin
            pre <= pre + DW'(1);
         end
      end
   end

   assign busy_o = busy_q;

   // R8
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
   parameter int AW           = 8,
   parameter int PW           = 3,
   parameter int DW           = 8,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [AW-1:0]                 rd_addr_i,
   output logic [DW-1:0]                 rd_data_o,
   input  logic                          commit_i,
   input  logic [AW-PW-1:0]              page_i,
   input  logic [(1<<PW)-1:0]            mask_i,
   input  logic [(1<<PW)-1:0][DW-1:0]    data_i
);

   localparam int DEPTH = 1 << AW;
   localparam int PAGE  = 1 << PW;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (ERASED_RESET) begin : g_erase
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            end else if (commit_i) begin
               for (int s = 0; s < PAGE; s++)
                  if (mask_i[s]) mem[{page_i, PW'(s)}] <= data_i[s];
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (commit_i) begin
               for (int s = 0; s < PAGE; s++)
                  if (mask_i[s]) mem[{page_i, PW'(s)}] <= data_i[s];
            end
         end
      end
   endgenerate

   assign rd_data_o = mem[rd_addr_i];

   // R4
   commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (mask_i != '0));

endmodule

// File: rtl/sermem_i2c_slave.sv
module sermem_i2c_slave
   import sermem_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int PAGE_W       = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int WR_DIV       = 128,
   parameter int WR_TICKS     = 16,
   parameter bit ERASED_RESET = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   output logic       sda_oe_o
);

   localparam int PAGE = 1 << PAGE_W;
   localparam int PG_W = ADDR_W - PAGE_W;

   generate
      if (ADDR_W > BYTE_W || PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_geom
         $error("sermem_i2c_slave: need 1 <= PAGE_W < ADDR_W <= 8");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   sermem_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   bus_st_e                        st;
   logic [3:0]                     bcnt;
   logic [BYTE_W-1:0]              sh;
   logic [BYTE_W-1:0]              tx;
   logic [ADDR_W-1:0]              ptr;
   logic [ADDR_W-1:0]              rd_addr;
   logic [BYTE_W-1:0]              rd_data;
   logic                           drive_q;
   logic                           rw_q;
   logic                           mack;
   logic [PAGE-1:0]                vmask;
   logic [PAGE-1:0][BYTE_W-1:0]    latch;
   logic                           commit;
   logic                           wr_busy;
   logic                           byte_done;
   logic                           rx_state;
   logic                           sel_match;

   assign byte_done = scl_fall && (bcnt == 4'd8);
   assign rx_state  = (st == ST_SEL) || (st == ST_ADR) || (st == ST_WR);
   assign sel_match = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap_i) && !wr_busy;
   assign commit    = stop_det && (|vmask);
   assign rd_addr   = (st == ST_RD_ACK) ? ptr + ADDR_W'(1) : ptr;

   sermem_wtimer #(.DIV(WR_DIV), .TICKS(WR_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit),
      .busy_o  (wr_busy)
   );

   sermem_array #(
      .AW(ADDR_W), .PW(PAGE_W), .DW(BYTE_W), .ERASED_RESET(ERASED_RESET)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .commit_i  (commit),
      .page_i    (ptr[ADDR_W-1:PAGE_W]),
      .mask_i    (vmask),
      .data_i    (latch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bcnt    <= '0;
         sh      <= '0;
         tx      <= '0;
         ptr     <= '0;
         drive_q <= 1'b0;
         rw_q    <= 1'b0;
         mack    <= 1'b0;
         vmask   <= '0;
         latch   <= '0;
      end else if (start_det) begin
         st      <= ST_SEL;
         bcnt    <= '0;
         drive_q <= 1'b0;
         vmask   <= '0;
      end else if (stop_det) begin
         st      <= ST_IDLE;
         drive_q <= 1'b0;
         vmask   <= '0;
      end else begin
         if (rx_state && scl_rise && bcnt < 4'd8) begin
            sh   <= {sh[BYTE_W-2:0], sda_s};
            bcnt <= bcnt + 4'd1;
         end
         case (st)
            ST_SEL: if (byte_done) begin
               if (sel_match) begin
                  rw_q    <= sh[0];
                  drive_q <= 1'b1;
                  st      <= ST_SEL_ACK;
               end else begin
                  st <= ST_SKIP;
               end
            end
            ST_SEL_ACK: if (scl_fall) begin
               bcnt <= '0;
               if (rw_q) begin
                  tx      <= rd_data;
                  drive_q <= ~rd_data[BYTE_W-1];
                  st      <= ST_RD;
               end else begin
                  drive_q <= 1'b0;
                  st      <= ST_ADR;
               end
            end
            ST_ADR: if (byte_done) begin
               ptr     <= sh[ADDR_W-1:0];
               drive_q <= 1'b1;
               st      <= ST_ADR_ACK;
            end
            ST_WR: if (byte_done) begin
               latch[ptr[PAGE_W-1:0]] <= sh;
               vmask[ptr[PAGE_W-1:0]] <= 1'b1;
               ptr[PAGE_W-1:0]        <= ptr[PAGE_W-1:0] + PAGE_W'(1);
               drive_q                <= 1'b1;
               st                     <= ST_WR_ACK;
            end
            ST_ADR_ACK, ST_WR_ACK: if (scl_fall) begin
               drive_q <= 1'b0;
               bcnt    <= '0;
               st      <= ST_WR;
            end
            ST_RD: if (scl_fall) begin
               if (bcnt == 4'd7) begin
                  drive_q <= 1'b0;
                  bcnt    <= '0;
                  st      <= ST_RD_ACK;
               end else begin
                  tx      <= {tx[BYTE_W-2:0], 1'b0};
                  drive_q <= ~tx[BYTE_W-2];
                  bcnt    <= bcnt + 4'd1;
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) mack <= ~sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     ptr     <= ptr + ADDR_W'(1);
                     tx      <= rd_data;
                     drive_q <= ~rd_data[BYTE_W-1];
                     bcnt    <= '0;
                     st      <= ST_RD;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = drive_q;

   // R8
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEL_ACK) |-> !wr_busy);

   // R2
   oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(scl_fall));

   // R2
   oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

   // R9
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (vmask == '0));

   // R5
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR && byte_done && !start_det && !stop_det)
         |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

   // R7
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD_ACK && scl_fall && mack && ptr == '1 && !start_det && !stop_det)
         |=> (ptr == '0));

endmodule

// File: tb/test_sermem_i2c_slave.sv
`timescale 1ns/1ps
module test_sermem_i2c_slave;

   localparam int Q       = 5;
   localparam int WR_CYC  = 128 * 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       sda_oe;
   logic       sda_bus;

   int    n_chk = 0;
   int    n_err = 0;
   logic  win_on = 1'b0;
   logic  win_oe = 1'b0;
   string win_tag = "";
   logic [7:0] ref_mem [256];
   logic [7:0] wq [$];

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   sermem_i2c_slave i_sermem_i2c_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .strap_i  (strap),
      .sda_oe_o (sda_oe)
   );

   // per-clock comparison of the drive enable during SCL-high windows
   always @(negedge clk) begin
      if (win_on) begin
         n_chk++;
         if (sda_oe !== win_oe) begin
            n_err++;
            $display("FAIL %s (R2 window) actual oe=%b expected oe=%b", win_tag, sda_oe, win_oe);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, input logic eoe, input string tag, output logic seen);
      sda_m = b;
      tick(Q);
      scl = 1'b1;
      tick(2);
      win_tag = tag;
      win_oe  = eoe;
      win_on  = 1'b1;
      tick(2 * Q - 4);
      seen   = sda_bus;
      win_on = 1'b0;
      tick(2);
      scl = 1'b0;
      tick(Q);
   endtask

   task automatic do_start();
      sda_m = 1'b1;
      tick(Q);
      scl = 1'b1;
      tick(2 * Q);
      sda_m = 1'b0;
      tick(2 * Q);
      scl = 1'b0;
      tick(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0;
      tick(Q);
      scl = 1'b1;
      tick(2 * Q);
      sda_m = 1'b1;
      tick(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic eack, input string tag);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, tag, s);
      clk_bit(1'b1, eack, tag, s);
      chk(s == !eack, {tag, " ack"}, int'(s), int'(!eack));
   endtask

   task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
      logic       s;
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, !exp[i], tag, s);
         got[i] = s;
      end
      clk_bit(!mack, 1'b0, tag, s);
      chk(got == exp, {tag, " data"}, int'(got), int'(exp));
   endtask

   function automatic logic [7:0] sel(input logic [2:0] st, input logic rd);
      return {4'b1010, st, rd};
   endfunction

   task automatic wr_txn(input logic [7:0] a, input string tag);
      do_start();
      send_byte(sel(strap, 1'b0), 1'b1, tag);
      send_byte(a, 1'b1, tag);
      foreach (wq[i]) send_byte(wq[i], 1'b1, tag);
      do_stop();
      foreach (wq[i]) ref_mem[{a[7:3], 3'(int'(a[2:0]) + i)}] = wq[i];
      wq.delete();
   endtask

   task automatic rd_txn(input logic [7:0] a, input int n, input string tag);
      do_start();
      send_byte(sel(strap, 1'b0), 1'b1, tag);
      send_byte(a, 1'b1, tag);
      do_start();
      send_byte(sel(strap, 1'b1), 1'b1, tag);
      for (int k = 0; k < n; k++)
         recv_byte(ref_mem[8'(int'(a) + k)], (k < n - 1), tag);
      do_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      tick(10);
      rst_n = 1'b1;
      tick(10);

      // R3: released after reset
      chk(sda_oe == 1'b0, "R3 reset oe", int'(sda_oe), 0);

      // R1: wrong straps, wrong device code
      do_start();
      send_byte(sel(3'b011, 1'b0), 1'b0, "R1 wrong strap");
      do_stop();
      do_start();
      send_byte({4'b1011, strap, 1'b0}, 1'b0, "R1 wrong code");
      do_stop();

      // R4: single byte write
      wq.push_back(8'h5A);
      wr_txn(8'h10, "R4 byte write");

      // R8: silent while the write cycle runs
      do_start();
      send_byte(sel(strap, 1'b0), 1'b0, "R8 busy nack");
      do_stop();
      tick(WR_CYC + 300);
      do_start();
      send_byte(sel(strap, 1'b0), 1'b1, "R8 ack after cycle");
      do_stop();

      // R6 / R3 / R4: random read of written byte and erased neighbours
      rd_txn(8'h10, 2, "R6 random read");
      rd_txn(8'h0F, 1, "R3 erased");

      // R5: ten bytes into one page starting at slot 2
      for (int i = 0; i < 10; i++) wq.push_back(8'(8'hA0 + i));
      wr_txn(8'h22, "R5 page write");
      tick(WR_CYC + 100);

      // R7: sequential read across page boundaries
      rd_txn(8'h1E, 12, "R7 sequential");

      // R7: wrap from 0xFF to 0x00
      wq.push_back(8'hC3);
      wr_txn(8'hFF, "R4 write top");
      tick(WR_CYC + 100);
      wq.push_back(8'h3C);
      wr_txn(8'h00, "R4 write bottom");
      tick(WR_CYC + 100);
      rd_txn(8'hFE, 3, "R7 wrap");

      // R9: repeated START discards latched data, no write cycle
      do_start();
      send_byte(sel(strap, 1'b0), 1'b1, "R9 abort");
      send_byte(8'h40, 1'b1, "R9 abort");
      send_byte(8'h77, 1'b1, "R9 abort");
      send_byte(8'h88, 1'b1, "R9 abort");
      do_start();
      send_byte(sel(strap, 1'b1), 1'b1, "R9 not busy");
      recv_byte(ref_mem[8'h42], 1'b0, "R9 read after abort");
      do_stop();
      rd_txn(8'h40, 2, "R9 unchanged");

      // R1: new strap setting
      strap = 3'b010;
      do_start();
      send_byte(sel(3'b101, 1'b0), 1'b0, "R1 old strap");
      do_stop();
      rd_txn(8'h10, 1, "R1 new strap");

      // R7: NACK ends read, slave stays released
      tick(20);
      chk(sda_oe == 1'b0, "R7 released", int'(sda_oe), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule